// File: doc/BRIEF.md
# TLB Miss Assist Register Loader

When an address lookup misses in the translation buffer, this block fills the six assist registers that the miss handler later edits and writes back as a new entry. It fills them in the single clock cycle after the miss strobe. Most fields come from a defaults register. The handler therefore starts from a prepared template and does not have to assemble every field itself. The block fills in the page number of the faulting address, the address-space bit, the translation ID and a suggested way for replacement.

A round-robin victim counter runs over the ways of the first array. On each miss, its current value is offered as the entry to replace, and its next value is reported as the following victim. The faulting address and a store flag in a syndrome word are latched with the same update. A one-cycle done pulse marks the update.

Top module: `tlb_miss_loader`

## Requirements
- R1: After reset, every register output is zero, done_o is low and the victim counter is zero.
- R2: On a miss, only these fields are copied from defaults_i: MAS0 bits [29:28] from defaults_i[29:28] (array select), MAS1 bits [11:8] from defaults_i[11:8] (size), and MAS2 bits [4:0] from defaults_i[4:0] (storage attributes). MAS3 and MAS7 become zero.
- R3: The access kind is encoded as 0 = read, 1 = write, 2 = fetch, and 3 is treated as a read. On a miss, MAS1 bit 12 and MAS6 bit 0 are both set to ir_i for a fetch and to dr_i for any other kind.
- R4: On a miss, MAS1 bit 31 (valid) is set, and MAS2 bits [31:12] take miss_addr_i[31:12].
- R5: defaults_i[17:16] selects the value of MAS1 bits [23:16]: 0 gives pid0_i, 1 gives pid1_i, 2 gives pid2_i, and 3 gives zero.
- R6: On a miss, MAS6 bits [23:16] take pid0_i.
- R7: On a miss, MAS0 bits [19:16] take the victim counter. The counter then advances by one modulo WAYS, and MAS0 bits [3:0] take the advanced value. All other MAS0 bits are zero.
- R8: On a miss, fault_addr_o takes miss_addr_i. syndrome_o becomes zero except bit 23, which is set only for a write.
- R9: All updates appear one cycle after the strobe, and done_o is high for exactly that cycle. Without a strobe, all register outputs hold whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| miss_i | input | 1 | Miss strobe |
| miss_addr_i | input | 32 | Faulting address |
| kind_i | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| ir_i | input | 1 | Instruction relocation on |
| dr_i | input | 1 | Data relocation on |
| defaults_i | input | 32 | Defaults register (MAS4) |
| pid0_i | input | PID_W | Process ID 0 |
| pid1_i | input | PID_W | Process ID 1 |
| pid2_i | input | PID_W | Process ID 2 |
| mas0_o | output | 32 | Array select, entry select, next victim |
| mas1_o | output | 32 | Valid, TID, space, size |
| mas2_o | output | 32 | Page number, attributes |
| mas3_o | output | 32 | Cleared on miss |
| mas6_o | output | 32 | Search PID, search space |
| mas7_o | output | 32 | Cleared on miss |
| fault_addr_o | output | 32 | Latched fault address |
| syndrome_o | output | 32 | Store flag at bit 23 |
| done_o | output | 1 | Update pulse |

## Verification
Misses are driven with all four access kinds under every combination of the two relocation bits. This separates the fetch path of the space bit from the data path and shows that only writes set the store flag. Each of the four ID-select encodings is tried with distinct PID values, so a wrong mux leg shows up. More than WAYS back-to-back misses check the wrap of the victim counter. Idle cycles with changing inputs, and a reset in the middle of the run, show that outputs hold and that the counter restarts.

// File: rtl/tlb_miss_loader.sv
module tlb_miss_loader #(
  parameter int WAYS     = 4,
  parameter int PID_W    = 8,
  parameter int PAGE_LSB = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             miss_i,
  input  logic [31:0]      miss_addr_i,
  input  logic [1:0]       kind_i,
  input  logic             ir_i,
  input  logic             dr_i,
  input  logic [31:0]      defaults_i,
  input  logic [PID_W-1:0] pid0_i,
  input  logic [PID_W-1:0] pid1_i,
  input  logic [PID_W-1:0] pid2_i,
  output logic [31:0]      mas0_o,
  output logic [31:0]      mas1_o,
  output logic [31:0]      mas2_o,
  output logic [31:0]      mas3_o,
  output logic [31:0]      mas6_o,
  output logic [31:0]      mas7_o,
  output logic [31:0]      fault_addr_o,
  output logic [31:0]      syndrome_o,
  output logic             done_o
);
  localparam int VW = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam logic [31:0] PAGE_MASK = ~((32'd1 << PAGE_LSB) - 32'd1);

  logic [VW-1:0] victim;
  logic [VW-1:0] victim_nx;
  logic          space;
  logic          is_fetch;
  logic [7:0]    tid;
  logic [7:0]    spid;

  assign victim_nx = (WAYS > 1) ? victim + VW'(1) : '0;
  assign is_fetch  = (kind_i == 2'd2);
  assign space     = is_fetch ? ir_i : dr_i;
  assign spid      = 8'(pid0_i);

  always_comb begin
    case (defaults_i[17:16])
      2'd0:    tid = 8'(pid0_i);
      2'd1:    tid = 8'(pid1_i);
      2'd2:    tid = 8'(pid2_i);
      default: tid = 8'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      victim       <= '0;
      mas0_o       <= '0;
      mas1_o       <= '0;
      mas2_o       <= '0;
      mas3_o       <= '0;
      mas6_o       <= '0;
      mas7_o       <= '0;
      fault_addr_o <= '0;
      syndrome_o   <= '0;
      done_o       <= 1'b0;
    end else begin
      done_o <= miss_i;
      if (miss_i) begin
        victim       <= victim_nx;
        mas0_o       <= {2'b0, defaults_i[29:28], 8'b0, 4'(victim), 12'b0, 4'(victim_nx)};
        mas1_o       <= {1'b1, 7'b0, tid, 3'b0, space, defaults_i[11:8], 8'b0};
        mas2_o       <= (miss_addr_i & PAGE_MASK) | {27'b0, defaults_i[4:0]};
        mas3_o       <= '0;
        mas6_o       <= {8'b0, spid, 15'b0, space};
        mas7_o       <= '0;
        fault_addr_o <= miss_addr_i;
        syndrome_o   <= {8'b0, (kind_i == 2'd1), 23'b0};
      end
    end
  end

  a_r9_done_follows: assert property (@(posedge clk) disable iff (rst)
    miss_i |=> done_o);
  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    !miss_i |=> !done_o);
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !miss_i |=> ($stable(mas0_o) && $stable(mas1_o) && $stable(mas2_o) && $stable(fault_addr_o)));
  a_r2_cleared: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (mas3_o == 32'd0 && mas7_o == 32'd0));
  a_r4_valid: assert property (@(posedge clk) disable iff (rst)
    done_o |-> mas1_o[31]);
  a_r7_next_victim: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (mas0_o[3:0] == ((mas0_o[19:16] + 4'd1) & 4'(WAYS - 1))));
  a_r3_space_agree: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (mas1_o[12] == mas6_o[0]));
  a_r8_addr: assert property (@(posedge clk) disable iff (rst)
    miss_i |=> (fault_addr_o == $past(miss_addr_i)));
endmodule

// File: tb/tb_tlb_miss_loader.sv
module tb_tlb_miss_loader;
  localparam int WAYS = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        miss = 1'b0;
  logic [31:0] addr = '0;
  logic [1:0]  kind = '0;
  logic        ir = 1'b0, dr = 1'b0;
  logic [31:0] dflt = '0;
  logic [7:0]  p0 = 8'h11, p1 = 8'h22, p2 = 8'h33;
  logic [31:0] mas0, mas1, mas2, mas3, mas6, mas7, fa, syn;
  logic        done;

  int errors = 0, checks = 0, cycles = 0;
  bit started = 0;

  always #10 clk = ~clk;

  tlb_miss_loader #(.WAYS(WAYS), .PID_W(8), .PAGE_LSB(12)) dut (
    .clk(clk), .rst(rst), .miss_i(miss), .miss_addr_i(addr), .kind_i(kind),
    .ir_i(ir), .dr_i(dr), .defaults_i(dflt), .pid0_i(p0), .pid1_i(p1), .pid2_i(p2),
    .mas0_o(mas0), .mas1_o(mas1), .mas2_o(mas2), .mas3_o(mas3), .mas6_o(mas6),
    .mas7_o(mas7), .fault_addr_o(fa), .syndrome_o(syn), .done_o(done));

  // reference model
  int          m_vic;
  logic [31:0] e0, e1, e2, e3, e6, e7, ef, es;
  logic        ed;

  always @(posedge clk) begin
    if (rst) begin
      m_vic = 0; e0 = 0; e1 = 0; e2 = 0; e3 = 0; e6 = 0; e7 = 0; ef = 0; es = 0; ed = 0;
    end else begin
      ed = miss;
      if (miss) begin
        int  nxt;
        int  tidv;
        bit  sp;
        nxt = (m_vic + 1) % WAYS;
        sp = (kind == 2) ? ir : dr;
        case (dflt[17:16])
          0: tidv = p0;
          1: tidv = p1;
          2: tidv = p2;
          default: tidv = 0;
        endcase
        e0 = 0;
        e0[29:28] = dflt[29:28];
        e0 = e0 + (m_vic << 16) + nxt;
        e1 = 32'h8000_0000 + (tidv << 16) + (sp ? 32'h1000 : 0) + (dflt[11:8] << 8);
        e2 = {addr[31:12], 12'h0} + dflt[4:0];
        e3 = 0; e7 = 0;
        e6 = (p0 << 16) + (sp ? 1 : 0);
        ef = addr;
        es = (kind == 1) ? 32'h0080_0000 : 0;
        m_vic = nxt;
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      chk("R9 done", {31'b0, done}, {31'b0, ed});
      chk("R7 mas0", mas0, e0);
      chk("R5 mas1", mas1, e1);
      chk("R4 mas2", mas2, e2);
      chk("R2 mas3", mas3, e3);
      chk("R6 mas6", mas6, e6);
      chk("R2 mas7", mas7, e7);
      chk("R8 fault", fa, ef);
      chk("R8 syndrome", syn, es);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected<=5000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic step(input logic m, input logic [31:0] a, input logic [1:0] k,
                      input logic i_r, input logic d_r, input logic [31:0] d);
    @(negedge clk);
    miss = m; addr = a; kind = k; ir = i_r; dr = d_r; dflt = d;
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    started = 1;
    rst = 1'b0;
    // R1 reset state is checked by the compare on this first cycle
    step(0, 32'hdead_beef, 2'd1, 1, 1, 32'hffff_ffff);
    // R3 every kind under every relocation combination
    for (int k = 0; k < 4; k++)
      for (int r = 0; r < 4; r++)
        step(1, 32'h1234_5000 + (k << 20) + r * 32'h111, 2'(k), r[0], r[1],
             32'h2000_0315 + (r << 16));
    step(0, 32'h0, 2'd0, 0, 0, 32'h0);
    // R5 each TID select with distinct PIDs; R2 varied defaults
    p0 = 8'hA5; p1 = 8'h5A; p2 = 8'hC3;
    for (int s = 0; s < 4; s++) begin
      step(1, 32'hFFFF_FFFF - s, 2'd2, 1, 0, 32'h3000_0F1F | (s << 16));
      step(0, 32'h0bad_0000, 2'd1, 1, 1, 32'hffff_ffff);
    end
    // R7 back-to-back misses wrap the victim counter
    for (int n = 0; n < 2 * WAYS + 1; n++)
      step(1, 32'h0000_1000 * n, 2'(n % 3), n[0], ~n[0], 32'h1000_0000 | (n << 8));
    // R9 idle with moving inputs
    for (int n = 0; n < 4; n++) step(0, 32'h7777_0000 + n, 2'd1, 1, 1, 32'hffff_ffff);
    // R1 reset mid-run restarts the counter
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    step(1, 32'h8000_2000, 2'd1, 0, 1, 32'h0001_0203);
    step(1, 32'h8000_3000, 2'd0, 0, 0, 32'h0003_0203);
    step(0, 32'h0, 2'd0, 0, 0, 32'h0);
    step(0, 32'h0, 2'd0, 0, 0, 32'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule